// File: doc/BRIEF.md
# Operand-Tracking Reservation Pool

This block holds instructions for one class of functional unit (for example an add/subtract unit) between the moment they leave the issue stage and the moment the unit starts on them. Each incoming request carries an operation code, an immediate/address field and, for each of its two sources, either a finished value or the tag of the station that will produce that value. The pool accepts a request only while one of its slots is free. It reports the tag it will give to the next accepted request, so the rename logic outside can point later consumers at that slot.

Every slot that still waits for an operand compares the waiting tag against a single result broadcast bus on every cycle. On a match it copies the broadcast value and marks the operand present. A slot whose two operands are both present is offered to the functional unit. When several slots are ready at once, the lowest-numbered one goes first, and at most one slot goes per cycle. A slot stays occupied while its unit works. It is freed when its own tag appears on the broadcast bus, and it can be refilled on the next cycle. The functional unit, the fetch path and the register file are outside this block.

Top module: `rs_pool`

## Requirements
- R1: After reset every slot is free: `iss_ready` is 1, `disp_valid` is 0 and `iss_tag` equals `TAG_BASE` (1 by default).
- R2: A request is taken only in a cycle where `iss_valid` and `iss_ready` are both 1. It goes into the lowest-numbered free slot, and slot i carries tag `TAG_BASE`+i. When no slot is free, `iss_ready` is 0 and a request is dropped without changing any slot.
- R3: A source whose incoming tag is 0 is taken from the incoming value. A request with both source tags 0 shows on `disp_valid` in the cycle after the clock edge that accepts it.
- R4: A source with a nonzero tag is filled from the broadcast bus when `bc_valid` is 1 and `bc_tag` equals that tag. The tag then reads as cleared, and the slot can dispatch in the cycle after the last missing operand is broadcast.
- R5: If a broadcast happens in the same cycle as the issue that writes a slot, and its tag matches an incoming source tag, the broadcast value is written into the slot in place of the incoming value.
- R6: `disp_valid` offers the lowest-numbered slot that is waiting with both operands present. At most one slot is offered per cycle, and every offer is taken at the next edge, so a slot is offered exactly once per occupancy.
- R7: A slot is freed at the edge where its own tag appears on the broadcast bus with `bc_valid` 1. `iss_ready` and `iss_tag` show the freed slot from the following cycle.
- R8: While `disp_valid` is 1, the outputs `disp_op`, `disp_a`, `disp_b`, `disp_imm` and `disp_tag` carry the slot's operation code, its first and second operand values, its immediate field and its own tag.
- R9: A broadcast whose tag matches no waiting source leaves every operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request present |
| iss_op | input | OP_W | Operation code of the request |
| iss_tag_a | input | TAG_W | Producer tag of the first source, 0 when the value is present |
| iss_val_a | input | DATA_W | Value of the first source |
| iss_tag_b | input | TAG_W | Producer tag of the second source, 0 when the value is present |
| iss_val_b | input | DATA_W | Value of the second source |
| iss_imm | input | IMM_W | Immediate or address field |
| iss_ready | output | 1 | At least one slot is free |
| iss_tag | output | TAG_W | Tag the next accepted request will receive |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the producer being broadcast |
| bc_val | input | DATA_W | Broadcast result value |
| disp_valid | output | 1 | A ready slot is offered to the functional unit |
| disp_op | output | OP_W | Operation code of the offered slot |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| disp_imm | output | IMM_W | Immediate field |
| disp_tag | output | TAG_W | Tag of the offered slot |

## Verification
An issue with both operands present is due on `disp_valid` one cycle after its accepting edge. An operand broadcast makes the slot dispatchable one cycle after the broadcast cycle, and an own-tag broadcast shows up as a free slot one cycle after it. The bench drives every input at the falling edge and samples at the next falling edge, so each of these one-cycle results is read exactly where it is due. In the chained case, the stub unit takes two cycles from dispatch to broadcast, and the bench counts those stages to pick the single falling edge where the dependent slot must be offered and the one where the pool must be empty again.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // occupancy of one slot
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rs_first_pick.sv
// Finds the lowest set bit of a request vector.
module rs_first_pick #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/rs_operand.sv
// One source operand: holds a value or a producer tag, and snoops the broadcast bus.
module rs_operand #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [TAG_W-1:0]  in_tag,
  input  logic [DATA_W-1:0] in_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic [TAG_W-1:0]  tag_q,
  output logic [DATA_W-1:0] val_q
);
  logic [TAG_W-1:0]  tag_d;
  logic [DATA_W-1:0] val_d;
  logic              in_hit;
  logic              hold_hit;
  logic              upd;

  always_comb begin
    in_hit   = bc_valid && (in_tag != '0) && (in_tag == bc_tag);
    hold_hit = bc_valid && (tag_q != '0) && (tag_q == bc_tag);
    upd      = load || hold_hit;
    tag_d    = tag_q;
    val_d    = val_q;
    if (load) begin
      if (in_hit) begin
        tag_d = '0;
        val_d = bc_val;
      end else begin
        tag_d = in_tag;
        val_d = in_val;
      end
    end else if (hold_hit) begin
      tag_d = '0;
      val_d = bc_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q <= '0;
      val_q <= '0;
    end else if (upd) begin
      tag_q <= tag_d;
      val_q <= val_d;
    end
  end
endmodule

// File: rtl/rs_slot.sv
// One pool slot: occupancy state, operation, immediate and two operands.
module rs_slot
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 3,
  parameter int IMM_W  = 8,
  parameter int MY_TAG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [TAG_W-1:0]  ld_tag_a,
  input  logic [DATA_W-1:0] ld_val_a,
  input  logic [TAG_W-1:0]  ld_tag_b,
  input  logic [DATA_W-1:0] ld_val_b,
  input  logic [IMM_W-1:0]  ld_imm,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  input  logic              take,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op_q,
  output logic [DATA_W-1:0] val_a,
  output logic [DATA_W-1:0] val_b,
  output logic [IMM_W-1:0]  imm_q
);
  slot_state_e      state_q;
  slot_state_e      state_d;
  logic             own_hit;
  logic [TAG_W-1:0] tag_a;
  logic [TAG_W-1:0] tag_b;

  assign own_hit = bc_valid && (bc_tag == TAG_W'(MY_TAG));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_IDLE: if (load) state_d = SLOT_WAIT;
      SLOT_WAIT: begin
        if (own_hit)   state_d = SLOT_IDLE;
        else if (take) state_d = SLOT_EXEC;
      end
      SLOT_EXEC: if (own_hit) state_d = SLOT_IDLE;
      default:   state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SLOT_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      imm_q <= '0;
    end else if (load) begin
      op_q  <= ld_op;
      imm_q <= ld_imm;
    end
  end

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_a (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_tag(ld_tag_a), .in_val(ld_val_a),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .tag_q(tag_a), .val_q(val_a)
  );

  rs_operand #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_src_b (
    .clk(clk), .rst_n(rst_n), .load(load),
    .in_tag(ld_tag_b), .in_val(ld_val_b),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .tag_q(tag_b), .val_q(val_b)
  );

  assign busy  = (state_q != SLOT_IDLE);
  assign ready = (state_q == SLOT_WAIT) && (tag_a == '0) && (tag_b == '0);
endmodule

// File: rtl/rs_pool.sv
// Pool of reservation slots for one functional unit class.
module rs_pool
  import rs_pkg::*;
#(
  parameter int ENTRIES  = 4,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int OP_W     = 3,
  parameter int IMM_W    = 8,
  parameter int TAG_BASE = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_tag_a,
  input  logic [DATA_W-1:0] iss_val_a,
  input  logic [TAG_W-1:0]  iss_tag_b,
  input  logic [DATA_W-1:0] iss_val_b,
  input  logic [IMM_W-1:0]  iss_imm,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [IMM_W-1:0]  disp_imm,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] busy_vec;
  logic [ENTRIES-1:0] free_vec;
  logic [ENTRIES-1:0] ready_vec;
  logic [ENTRIES-1:0] load_vec;
  logic [ENTRIES-1:0] take_vec;
  logic [IW-1:0]      free_idx;
  logic [IW-1:0]      disp_idx;
  logic               free_found;
  logic               rdy_found;

  logic [OP_W-1:0]   op_arr  [ENTRIES];
  logic [DATA_W-1:0] a_arr   [ENTRIES];
  logic [DATA_W-1:0] b_arr   [ENTRIES];
  logic [IMM_W-1:0]  imm_arr [ENTRIES];

  assign free_vec = ~busy_vec;

  rs_first_pick #(.N(ENTRIES)) u_free_pick (
    .req(free_vec), .found(free_found), .idx(free_idx)
  );

  rs_first_pick #(.N(ENTRIES)) u_disp_pick (
    .req(ready_vec), .found(rdy_found), .idx(disp_idx)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign load_vec[g] = iss_valid && free_found && (free_idx == IW'(g));
    assign take_vec[g] = rdy_found && (disp_idx == IW'(g));

    rs_slot #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .IMM_W(IMM_W),
      .MY_TAG(TAG_BASE + g)
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load_vec[g]),
      .ld_op(iss_op),
      .ld_tag_a(iss_tag_a), .ld_val_a(iss_val_a),
      .ld_tag_b(iss_tag_b), .ld_val_b(iss_val_b),
      .ld_imm(iss_imm),
      .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
      .take(take_vec[g]),
      .busy(busy_vec[g]), .ready(ready_vec[g]),
      .op_q(op_arr[g]), .val_a(a_arr[g]), .val_b(b_arr[g]), .imm_q(imm_arr[g])
    );
  end

  assign iss_ready  = free_found;
  assign iss_tag    = TAG_W'(TAG_BASE) + TAG_W'(free_idx);

  assign disp_valid = rdy_found;
  assign disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);
  assign disp_op    = op_arr[disp_idx];
  assign disp_a     = a_arr[disp_idx];
  assign disp_b     = b_arr[disp_idx];
  assign disp_imm   = imm_arr[disp_idx];
endmodule

// File: rtl/rs_pool_chk.sv
// Property checker for rs_pool, attached by bind.
module rs_pool_chk #(
  parameter int ENTRIES  = 4,
  parameter int TAG_W    = 3,
  parameter int TAG_BASE = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_valid,
  input logic               iss_ready,
  input logic               bc_valid,
  input logic [TAG_W-1:0]   bc_tag,
  input logic               disp_valid,
  input logic [TAG_W-1:0]   disp_tag,
  input logic [ENTRIES-1:0] busy_v,
  input logic [ENTRIES-1:0] ready_v
);
  // R2: a request seen while full changes no occupancy
  assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready && !bc_valid) |=>
      ($countones(busy_v) == $past($countones(busy_v))));

  // R2: an accepted request occupies exactly one more slot
  assert_issue_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready && !bc_valid) |=>
      ($countones(busy_v) == $past($countones(busy_v)) + 1));

  for (genvar i = 0; i < ENTRIES; i++) begin : g_chk
    localparam logic [TAG_W-1:0]   MY_TAG = TAG_W'(TAG_BASE + i);
    localparam logic [ENTRIES-1:0] LOWER  = (ENTRIES'(1) << i) - ENTRIES'(1);

    // R7: own tag on the bus frees the slot
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bc_valid && (bc_tag == MY_TAG) && busy_v[i]) |=> !busy_v[i]);

    // R3: only an occupied slot with both operands present is offered
    assert_disp_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && (disp_tag == MY_TAG)) |-> (busy_v[i] && ready_v[i]));

    // R6: no lower-numbered slot is ready when this one is offered
    assert_lowest_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && (disp_tag == MY_TAG)) |-> ((ready_v & LOWER) == '0));

    // R6: an offer is not repeated on the next cycle
    assert_no_redispatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_valid && (disp_tag == MY_TAG)) |=> !(disp_valid && (disp_tag == MY_TAG)));
  end
endmodule

bind rs_pool rs_pool_chk #(
  .ENTRIES(ENTRIES), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .iss_valid(iss_valid), .iss_ready(iss_ready),
  .bc_valid(bc_valid), .bc_tag(bc_tag),
  .disp_valid(disp_valid), .disp_tag(disp_tag),
  .busy_v(busy_vec), .ready_v(ready_vec)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;
  localparam int CLK_NS = 10;

  logic        clk;
  logic        rst_n;
  logic        iv;
  logic [2:0]  iop;
  logic [2:0]  ita, itb;
  logic [15:0] iva, ivb;
  logic [7:0]  iimm;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        bc_valid;
  logic [2:0]  bc_tag;
  logic [15:0] bc_val;
  logic        disp_valid;
  logic [2:0]  disp_op;
  logic [15:0] disp_a, disp_b;
  logic [7:0]  disp_imm;
  logic [2:0]  disp_tag;

  logic        ext_v;
  logic [2:0]  ext_tag;
  logic [15:0] ext_val;
  logic        stub_on;
  logic        s1_v, s2_v;
  logic [2:0]  s1_tag, s2_tag;
  logic [15:0] s1_res, s2_res;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  rs_pool uut (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iv), .iss_op(iop),
    .iss_tag_a(ita), .iss_val_a(iva),
    .iss_tag_b(itb), .iss_val_b(ivb),
    .iss_imm(iimm),
    .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_imm(disp_imm),
    .disp_tag(disp_tag)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  function automatic logic [15:0] fu(input logic [2:0] op, input logic [15:0] a,
                                     input logic [15:0] b, input logic [7:0] imm);
    case (op[1:0])
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a + {8'h00, imm};
      default: return b - {8'h00, imm};
    endcase
  endfunction

  // two-cycle functional unit stub
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0;
      s1_tag <= '0; s2_tag <= '0;
      s1_res <= '0; s2_res <= '0;
    end else begin
      s1_v   <= stub_on && disp_valid;
      s1_tag <= disp_tag;
      s1_res <= fu(disp_op, disp_a, disp_b, disp_imm);
      s2_v   <= s1_v;
      s2_tag <= s1_tag;
      s2_res <= s1_res;
    end
  end

  assign bc_valid = stub_on ? s2_v   : ext_v;
  assign bc_tag   = stub_on ? s2_tag : ext_tag;
  assign bc_val   = stub_on ? s2_res : ext_val;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [2:0] ta, input logic [15:0] va,
                       input logic [2:0] tb, input logic [15:0] vb, input logic [7:0] imm);
    iv = 1'b1; iop = op; ita = ta; iva = va; itb = tb; ivb = vb; iimm = imm;
    tick();
    iv = 1'b0;
  endtask

  task automatic bcast(input logic [2:0] t, input logic [15:0] v);
    ext_v = 1'b1; ext_tag = t; ext_val = v;
    tick();
    ext_v = 1'b0;
  endtask

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] ea, eb;
    rst_n = 1'b0; iv = 1'b0; iop = '0; ita = '0; itb = '0; iva = '0; ivb = '0;
    iimm = '0; ext_v = 1'b0; ext_tag = '0; ext_val = '0; stub_on = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state
    chk("R1 iss_ready", iss_ready, 1);
    chk("R1 disp_valid", disp_valid, 0);
    chk("R1 iss_tag", iss_tag, 1);

    // both operands present at issue
    issue(3'd2, 3'd0, 16'd10, 3'd0, 16'd3, 8'd5);
    chk("R3 disp_valid after issue", disp_valid, 1);
    chk("R8 disp_tag", disp_tag, 1);
    chk("R8 disp_op", disp_op, 2);
    chk("R8 disp_a", disp_a, 10);
    chk("R8 disp_b", disp_b, 3);
    chk("R8 disp_imm", disp_imm, 5);
    chk("R2 next iss_tag", iss_tag, 2);
    tick();
    chk("R6 offered once", disp_valid, 0);
    bcast(3'd1, 16'd0);
    chk("R7 slot 1 free again", iss_tag, 1);
    chk("R7 iss_ready", iss_ready, 1);

    // sweep of which sources wait on the bus
    for (int m = 0; m < 4; m++) begin
      ita = 3'(m[0] ? 5 : 0);
      itb = 3'(m[1] ? 6 : 0);
      ea  = m[0] ? 16'h0a00 + 16'(m) : 16'h0100 + 16'(m);
      eb  = m[1] ? 16'h0b00 + 16'(m) : 16'h0200 + 16'(m);
      issue(3'(m), 3'(m[0] ? 5 : 0), m[0] ? 16'hdead : 16'h0100 + 16'(m),
            3'(m[1] ? 6 : 0), m[1] ? 16'hbeef : 16'h0200 + 16'(m), 8'(m));
      chk("R4 ready at issue only when no tags", disp_valid, (m == 0));
      if (m != 0) begin
        bcast(3'd7, 16'h5555);
        chk("R9 unrelated tag ignored", disp_valid, 0);
        if (m[0]) begin
          bcast(3'd5, 16'h0a00 + 16'(m));
          chk("R4 first operand captured", disp_valid, !m[1]);
        end
        if (m[1]) begin
          bcast(3'd6, 16'h0b00 + 16'(m));
          chk("R4 second operand captured", disp_valid, 1);
        end
      end
      chk("R4 disp_a value", disp_a, ea);
      chk("R4 disp_b value", disp_b, eb);
      chk("R8 disp_imm sweep", disp_imm, m);
      tick();
      bcast(3'd1, 16'd0);
      chk("R7 freed after sweep step", iss_tag, 1);
    end

    // broadcast in the issue cycle
    iv = 1'b1; iop = 3'd1; ita = 3'd5; iva = 16'hdead; itb = 3'd0; ivb = 16'd7; iimm = 8'd0;
    ext_v = 1'b1; ext_tag = 3'd5; ext_val = 16'h0077;
    tick();
    iv = 1'b0; ext_v = 1'b0;
    chk("R5 forwarded slot ready", disp_valid, 1);
    chk("R5 forwarded value", disp_a, 16'h0077);
    chk("R5 other operand", disp_b, 7);
    tick();
    bcast(3'd1, 16'd0);

    // fill the pool, drop when full, then drain in priority order
    for (int k = 0; k < 4; k++) begin
      chk("R2 lowest free tag", iss_tag, 1 + k);
      issue(3'd0, 3'd5, 16'hdead, 3'd0, 16'h0030 + 16'(k), 8'd0);
    end
    chk("R2 full pool not ready", iss_ready, 0);
    issue(3'd3, 3'd0, 16'd1, 3'd0, 16'd2, 8'd3);
    chk("R2 request dropped when full", disp_valid, 0);
    bcast(3'd5, 16'h0099);
    for (int k = 0; k < 4; k++) begin
      chk("R6 offer order valid", disp_valid, 1);
      chk("R6 offer order tag", disp_tag, 1 + k);
      chk("R6 offer order data", disp_b, 16'h0030 + 16'(k));
      chk("R4 shared capture", disp_a, 16'h0099);
      tick();
    end
    chk("R6 nothing left to offer", disp_valid, 0);
    chk("R2 still full", iss_ready, 0);
    bcast(3'd3, 16'd0);
    chk("R7 middle slot freed", iss_ready, 1);
    chk("R7 middle slot tag", iss_tag, 3);
    bcast(3'd1, 16'd0);
    bcast(3'd2, 16'd0);
    bcast(3'd4, 16'd0);
    chk("R7 all freed", iss_tag, 1);

    // dependent pair through the two-cycle stub
    stub_on = 1'b1;
    for (int op = 0; op < 4; op++) begin
      issue(3'(op), 3'd0, 16'h0040 + 16'(op * 3), 3'd0, 16'h0011 + 16'(op), 8'(2 + op));
      issue(3'(op) ^ 3'd1, 3'd1, 16'hdead, 3'd0, 16'd5, 8'd1);
      tick();
      tick();
      chk("R4 dependent offered", disp_valid, 1);
      chk("R8 dependent tag", disp_tag, 2);
      chk("R4 dependent operand", disp_a,
          fu(3'(op), 16'h0040 + 16'(op * 3), 16'h0011 + 16'(op), 8'(2 + op)));
      repeat (3) tick();
      chk("R7 pool drained", iss_tag, 1);
      chk("R6 no stale offer", disp_valid, 0);
    end
    stub_on = 1'b0;
    tick();
    finish_run();
  end
endmodule